// File: doc/BRIEF.md
# Runtime Programmable Clock Prescaler

This block lowers the effective speed of a chip's core and peripheral logic to save power when little processing is needed. It stays in the master oscillator domain and does not build a second clock. It drives a one-cycle enable strobe instead. Every downstream consumer qualifies its registers with that strobe, so all of them slow down by the same factor.

Software controls the block through one 8-bit register on a plain register bus (address, write strobe, write data, read data). The top bit switches division on and off. The lower seven bits hold a divide code `d`. With division on, the strobe fires once every `129 - d` master cycles. With division off, it is high on every cycle.

The code is write-locked. It is taken only by a write that turns division on while division is off. Any other write leaves the stored code as it was.

Top module: `clkdiv_prescaler`

## Requirements
- R1: The control register sits at bus address `REG_ADDR` (default 0). Bit 7 is the divide enable and bits 6..0 are the divide code. A read at that address returns {enable, code}, and a read at any other address returns zero.
- R2: After reset the register reads 0x00 and the strobe is high on every cycle.
- R3: While enabled, the strobe is high for exactly one cycle in every `129 - d` master cycles.
- R4: While disabled, the strobe is high on every cycle, starting with the cycle that follows the write that cleared the enable.
- R5: A write with bit 7 equal to 0 clears the enable and discards its code bits. The stored code keeps its old value, whether the enable was set or already clear.
- R6: A write with bit 7 equal to 1 while the enable is clear loads its bits 6..0 as the new code and restarts the count from zero. In the cycles after that write edge, numbered from 0, the first strobe falls in cycle `128 - d`.
- R7: A write with bit 7 equal to 1 while the enable is already set changes neither the stored code nor the strobe phase.
- R8: Code 127 gives a strobe on every second cycle, and code 0 gives one strobe every 129 cycles.
- R9: A write to an address other than `REG_ADDR` changes neither the register nor the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Register bus address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | CODE_W+1 (8) | Write data: enable in the top bit, code below it |
| bus_rdata | output | CODE_W+1 (8) | Read data, combinational from bus_addr |
| tick_o | output | 1 | Divided clock-enable strobe |

## Verification
A write takes effect on the rising edge where `bus_wr` is sampled high. The strobe for the cycle after that edge already reflects the new register state. When division is switched on, the strobe stays low for cycles 0 through `127 - d` and rises in cycle `128 - d`. `bus_rdata` follows `bus_addr` within the same cycle. The bench therefore queues, for every cycle after a write, the strobe value that these counts predict, and compares each value at the falling edge of its cycle. When a later write must land mid-period, the bench counts the idle cycles its driver spends and passes that count as a phase offset, so the expected strobe positions stay aligned with the design's counter.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   // How a bus write to the control register is handled
   typedef enum logic [1:0] {
      WR_NONE = 2'd0,   // no write to this register
      WR_LOAD = 2'd1,   // enable rises: take the code, restart the count
      WR_DROP = 2'd2,   // enable cleared: code bits discarded
      WR_HOLD = 2'd3    // enable stays set: nothing changes
   } wr_kind_e;

endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
   import clkdiv_pkg::*;
#(
   parameter int CODE_W   = 7,
   parameter int ADDR_W   = 4,
   parameter int REG_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [CODE_W:0]   bus_wdata,
   output logic              div_en,
   output logic [CODE_W-1:0] div_code,
   output logic              restart
);

   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

   logic     wr_hit;
   wr_kind_e wr_kind;

   assign wr_hit = bus_wr && (bus_addr == HIT_ADDR);

   always_comb begin
      if (!wr_hit)
         wr_kind = WR_NONE;
      else if (!bus_wdata[CODE_W])
         wr_kind = WR_DROP;
      else if (!div_en)
         wr_kind = WR_LOAD;
      else
         wr_kind = WR_HOLD;
   end

   assign restart = (wr_kind == WR_LOAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_en   <= 1'b0;
         div_code <= '0;
      end else begin
         case (wr_kind)
            WR_LOAD: begin
               div_en   <= 1'b1;
               div_code <= bus_wdata[CODE_W-1:0];
            end
            WR_DROP: div_en <= 1'b0;
            default: ;
         endcase
      end
   end

   // R5
   code_kept_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !bus_wdata[CODE_W]) |=> ($stable(div_code) && !div_en));

   // R7
   hold_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && div_en && bus_wdata[CODE_W]) |=> ($stable(div_code) && div_en));

   // R6
   load_takes_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !div_en && bus_wdata[CODE_W]) |=>
         (div_en && div_code == $past(bus_wdata[CODE_W-1:0])));

   // R9
   foreign_addr_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> ($stable(div_code) && $stable(div_en)));

endmodule

// File: rtl/clkdiv_tick.sv
module clkdiv_tick #(
   parameter int CODE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              div_en,
   input  logic [CODE_W-1:0] div_code,
   input  logic              restart,
   output logic              tick_o
);

   // Count width holds 0 .. 2**CODE_W, the last index for code 0
   localparam int CNT_W = CODE_W + 1;
   localparam logic [CNT_W-1:0] LAST_MAX = {1'b1, {CODE_W{1'b0}}};

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last_idx;
   logic             at_last;

   // factor = 2**CODE_W + 1 - d, so last index = 2**CODE_W - d
   assign last_idx = LAST_MAX - {1'b0, div_code};
   assign at_last  = (cnt == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart || !div_en || at_last)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   assign tick_o = !div_en || at_last;

   // R3
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_en |-> (cnt <= last_idx));

   // R3
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_en && tick_o) |=> (!div_en || !tick_o));

endmodule

// File: rtl/clkdiv_prescaler.sv
module clkdiv_prescaler #(
   parameter int CODE_W   = 7,
   parameter int ADDR_W   = 4,
   parameter int REG_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [CODE_W:0]   bus_wdata,
   output logic [CODE_W:0]   bus_rdata,
   output logic              tick_o
);

   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

   generate
      if (CODE_W < 1 || CODE_W > 15) begin : g_bad_code_w
         $error("clkdiv_prescaler: CODE_W out of range");
      end
      if (ADDR_W < 1) begin : g_bad_addr_w
         $error("clkdiv_prescaler: ADDR_W must be positive");
      end
      if (REG_ADDR < 0 || REG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("clkdiv_prescaler: REG_ADDR does not fit ADDR_W");
      end
   endgenerate

   logic              div_en;
   logic [CODE_W-1:0] div_code;
   logic              restart;

   clkdiv_ctrl #(
      .CODE_W  (CODE_W),
      .ADDR_W  (ADDR_W),
      .REG_ADDR(REG_ADDR)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .div_en   (div_en),
      .div_code (div_code),
      .restart  (restart)
   );

   clkdiv_tick #(
      .CODE_W(CODE_W)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_en  (div_en),
      .div_code(div_code),
      .restart (restart),
      .tick_o  (tick_o)
   );

   // R1: read mux
   assign bus_rdata = (bus_addr == HIT_ADDR) ? {div_en, div_code} : '0;

   // R4
   disabled_full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !div_en |-> tick_o);

   // R6
   restart_no_early_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(div_en) |-> !tick_o);

endmodule

// File: tb/clkdiv_prescaler_tb.sv
module clkdiv_prescaler_tb;

   localparam int CODE_W = 7;
   localparam int ADDR_W = 4;

   typedef struct {
      bit    exp;
      string tag;
   } item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_wr = 1'b0;
   logic [CODE_W:0]   bus_wdata = '0;
   logic [CODE_W:0]   bus_rdata;
   logic              tick_o;

   int    total = 0;
   int    bad = 0;
   item_t sb_q[$];

   clkdiv_prescaler #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .REG_ADDR(0)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .tick_o   (tick_o)
   );

   always #10 clk = ~clk;   // 50 MHz

   // Monitor: one queued strobe expectation per cycle
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         total++;
         if (tick_o !== it.exp) begin
            bad++;
            $display("FAIL %s: tick_o=%0b expected=%0b", it.tag, tick_o, it.exp);
         end
      end
   end

   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [CODE_W:0] d);
      @(posedge clk); #1;
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(posedge clk); #1;
      bus_wr   = 1'b0;
      bus_addr = '0;
   endtask

   // period 0 means undivided; phase = cycles already elapsed in the period
   task automatic expect_ticks(input int period, input int n, input int phase, input string tag);
      for (int i = 0; i < n; i++) begin
         item_t it;
         it.tag = tag;
         it.exp = (period == 0) ? 1'b1 : (((i + phase) % period) == period - 1);
         sb_q.push_back(it);
      end
      wait (sb_q.size() == 0);
   endtask

   task automatic check_read(input logic [ADDR_W-1:0] a, input logic [CODE_W:0] exp, input string tag);
      bus_addr = a;
      #1;
      total++;
      if (bus_rdata !== exp) begin
         bad++;
         $display("FAIL %s: rdata=0x%02h expected=0x%02h", tag, bus_rdata, exp);
      end
      bus_addr = '0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R2: reset state
      check_read(0, 8'h00, "R2 reset rdata");
      expect_ticks(0, 4, 0, "R2 reset full rate");

      // R5: disabled write discards code
      bus_write(0, 8'h05);
      expect_ticks(0, 3, 0, "R4 stays full rate");
      check_read(0, 8'h00, "R5 code dropped while disabled");

      // R6 / R3: enable with code 120 -> factor 9
      bus_write(0, 8'hF8);
      expect_ticks(9, 20, 0, "R6 R3 factor 9");
      check_read(0, 8'hF8, "R1 readback after load");

      // R5: clearing keeps the code
      bus_write(0, 8'h00);
      expect_ticks(0, 2, 0, "R4 after clear");
      check_read(0, 8'h78, "R5 code kept on clear");

      // R7: hold write mid-period keeps code and phase
      bus_write(0, 8'hF8);
      expect_ticks(9, 4, 0, "R6 restart");
      bus_write(0, 8'h83);
      expect_ticks(9, 12, 5, "R7 phase kept");
      check_read(0, 8'hF8, "R7 code kept");

      // R4 / R5: disable carrying a different code
      bus_write(0, 8'h09);
      expect_ticks(0, 3, 0, "R4 full rate after disable");
      check_read(0, 8'h78, "R5 code 9 discarded");

      // R9: foreign address
      bus_write(3, 8'h85);
      expect_ticks(0, 3, 0, "R9 strobe unchanged");
      check_read(0, 8'h78, "R9 register unchanged");
      check_read(3, 8'h00, "R1 unmapped read zero");

      // R8: boundary codes
      bus_write(0, 8'hFF);
      expect_ticks(2, 8, 0, "R8 code 127 factor 2");
      check_read(0, 8'hFF, "R1 readback code 127");
      bus_write(0, 8'h00);
      bus_write(0, 8'h80);
      expect_ticks(129, 260, 0, "R8 code 0 factor 129");
      check_read(0, 8'h80, "R1 readback code 0");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule